// File: doc/BRIEF.md
# Three-Mode Local Interrupt Timer

This block is a per-core interrupt timer. Software sets it up through a small register file, and the timer then raises a single interrupt-request pulse. The pulse carries an 8-bit vector chosen by software. There are three ways to run it:

- **One-shot and periodic:** an initial count is divided down by a programmable prescaler, then counted to zero.
- **Deadline:** the timer waits until a free-running 64-bit timestamp, supplied on an input port, reaches a stored absolute value.

Which registers are live depends on the selected mode. The registers that do not belong to the current mode read as zero and ignore writes. Any change of mode drops whatever timer was armed.

Register access is a plain single-cycle port:
- A write is taken on any clock edge where `wr_en` is high.
- Reads are combinational from `rd_addr`.

The interrupt output is a one-cycle pulse with no back-pressure. A consumer that cannot accept it must latch it.

Top module: `core_irq_timer`

## Requirements
- R1: After reset, the control register (address 0) reads 0x10000 (masked, one-shot, vector 0). Initial count (1), current count (2), divide (3) and deadline (4) all read 0, and `irq_valid` is low.
- R2: A control write stores vector bits 7:0, mask bit 16 and mode bits 18:17. While `sw_enable` is low, the stored mask bit is 1 whatever value was written.
- R3: While mask bit 16 is set, expiry produces no `irq_valid` pulse. Clearing the mask with a write that keeps the same mode leaves a running periodic count running.
- R4: In one-shot mode (mode 00), a nonzero initial-count write starts the count. Exactly N×F cycles after the write edge, where N is the count and F the divide factor, `irq_valid` is high for one cycle with `irq_vector` equal to the control vector. The current count then reads 0 and no further pulse follows.
- R5: In periodic mode (mode 01), the count reloads from the initial count on every expiry, giving a pulse every N×F cycles.
- R6: The divide code is {bit 3, bits 1:0} of the divide register. Codes 000 to 110 give a factor of 2, 4, 8, 16, 32, 64 and 128; code 111 gives a factor of 1.
- R7: An initial-count write of 0 stops the count and starts nothing; the current count reads 0.
- R8: An initial-count write while counting restarts the full interval from that write.
- R9: A control write whose mode field differs from the stored one cancels any armed count or deadline.
- R10: In deadline mode (mode 10), the current count reads 0 and initial-count writes are ignored.
- R11: In modes other than deadline, the deadline register reads 0 and writes to it are ignored.
- R12: In deadline mode, a deadline write stores the value and re-arms. The pulse fires on the first clock edge after the write at which the timestamp is at or past the deadline, including at once for a past value. A value of 0 leaves the timer disarmed.
- R13: Mode 11 behaves as one-shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_enable | input | 1 | Interrupt controller software-enable state |
| tsc | input | 64 | Free-running timestamp |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 64 | Register read data (combinational) |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request, 0 otherwise |

## Verification
The assertions take three things for granted about the inputs:
- At most one register access lands per cycle, so a mode change, a count load and a deadline arm never collide.
- The timestamp only moves forward.
- The divide register is not rewritten while a count is running, because the prescaler phase would then be undefined.

The stimulus keeps to these assumptions:
- It issues writes one at a time.
- It advances the timestamp by one every cycle from a fixed start.
- It changes the divide setting only after the previous count has expired or been cancelled.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int VEC_W    = 8;
  localparam int MASK_POS = 16;
  localparam int MODE_LSB = 17;
  localparam int DIV_MAXLOG = 7;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_INIT = 3'd1,
    RA_CUR  = 3'd2,
    RA_DIV  = 3'd3,
    RA_DL   = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    TM_ONESHOT  = 2'b00,
    TM_PERIODIC = 2'b01,
    TM_DEADLINE = 2'b10,
    TM_SPARE    = 2'b11
  } tmode_e;

  function automatic logic [2:0] div_code(input logic [3:0] raw);
    return {raw[3], raw[1:0]};
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int MAXLOG = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] code,
  output logic       tick
);
  localparam int PW = MAXLOG;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] limit;
  logic [2:0]    shift;

  always_comb begin
    shift = code + 3'd1;
    limit = '0;
    for (int i = 0; i < PW; i++) begin
      if (i < int'(shift)) limit[i] = 1'b1;
    end
  end

  assign tick = run && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart || !run) cnt_q <= '0;
    else if (tick)            cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_countdown.sv
`timescale 1ns/1ps
module tmr_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cancel,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] cur,
  output logic             running,
  output logic             expire
);
  logic last;
  assign last   = (cur == CNT_W'(1));
  assign expire = running && tick && last && !cancel && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= '0;
      running <= 1'b0;
    end else if (cancel) begin
      cur     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cur     <= load_val;
      running <= |load_val;
    end else if (running && tick) begin
      if (last) begin
        if (periodic) begin
          cur <= reload_val;
        end else begin
          cur     <= '0;
          running <= 1'b0;
        end
      end else begin
        cur <= cur - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_deadline.sv
`timescale 1ns/1ps
module tmr_deadline #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cancel,
  input  logic            arm_wr,
  input  logic [TS_W-1:0] wr_val,
  input  logic [TS_W-1:0] tsc,
  output logic [TS_W-1:0] dl_q,
  output logic            armed,
  output logic            expire
);
  assign expire = armed && !cancel && !arm_wr && (tsc >= dl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl_q  <= '0;
      armed <= 1'b0;
    end else if (cancel) begin
      armed <= 1'b0;
    end else if (arm_wr) begin
      dl_q  <= wr_val;
      armed <= |wr_val;
    end else if (expire) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/core_irq_timer.sv
`timescale 1ns/1ps
module core_irq_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TS_W  = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sw_enable,
  input  logic [TS_W-1:0]       tsc,
  input  logic                  wr_en,
  input  logic [2:0]            wr_addr,
  input  logic [TS_W-1:0]       wr_data,
  input  logic [2:0]            rd_addr,
  output logic [TS_W-1:0]       rd_data,
  output logic                  irq_valid,
  output logic [VEC_W-1:0]      irq_vector
);
  localparam int DATA_W = TS_W;

  tmode_e           mode_q;
  logic             mask_q;
  logic [VEC_W-1:0] vec_q;
  logic [CNT_W-1:0] init_q;
  logic [3:0]       div_q;

  tmode_e           new_mode;
  logic             ctrl_wr, mode_chg, init_ld, dl_wr, div_wr;
  logic             dl_mode, per_mode;
  logic             tick, cd_run, cd_exp, dl_arm, dl_exp;
  logic [CNT_W-1:0] cur_cnt;
  logic [TS_W-1:0]  dl_q;

  assign new_mode = tmode_e'(wr_data[MODE_LSB+1:MODE_LSB]);
  assign dl_mode  = (mode_q == TM_DEADLINE);
  assign per_mode = (mode_q == TM_PERIODIC);
  assign ctrl_wr  = wr_en && (wr_addr == RA_CTRL);
  assign mode_chg = ctrl_wr && (new_mode != mode_q);
  assign init_ld  = wr_en && (wr_addr == RA_INIT) && !dl_mode;
  assign dl_wr    = wr_en && (wr_addr == RA_DL) && dl_mode;
  assign div_wr   = wr_en && (wr_addr == RA_DIV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= TM_ONESHOT;
      mask_q <= 1'b1;
      vec_q  <= '0;
      init_q <= '0;
      div_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= new_mode;
        mask_q <= wr_data[MASK_POS] | ~sw_enable;
        vec_q  <= wr_data[VEC_W-1:0];
      end
      if (init_ld) init_q <= wr_data[CNT_W-1:0];
      if (div_wr)  div_q  <= {wr_data[3], 1'b0, wr_data[1:0]};
    end
  end

  tmr_prescaler #(.MAXLOG(DIV_MAXLOG)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cd_run),
    .restart (init_ld | mode_chg),
    .code    (div_code(div_q)),
    .tick    (tick)
  );

  tmr_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk        (clk),
    .rst_n      (rst_n),
    .cancel     (mode_chg),
    .load       (init_ld),
    .load_val   (wr_data[CNT_W-1:0]),
    .reload_val (init_q),
    .periodic   (per_mode),
    .tick       (tick),
    .cur        (cur_cnt),
    .running    (cd_run),
    .expire     (cd_exp)
  );

  tmr_deadline #(.TS_W(TS_W)) u_dl (
    .clk    (clk),
    .rst_n  (rst_n),
    .cancel (mode_chg),
    .arm_wr (dl_wr),
    .wr_val (wr_data),
    .tsc    (tsc),
    .dl_q   (dl_q),
    .armed  (dl_arm),
    .expire (dl_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= (cd_exp | dl_exp) & ~mask_q;
      irq_vector <= ((cd_exp | dl_exp) & ~mask_q) ? vec_q : '0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL: begin
        rd_data[VEC_W-1:0]            = vec_q;
        rd_data[MASK_POS]             = mask_q;
        rd_data[MODE_LSB+1:MODE_LSB]  = mode_q;
      end
      RA_INIT: rd_data[CNT_W-1:0] = init_q;
      RA_CUR:  rd_data[CNT_W-1:0] = dl_mode ? '0 : cur_cnt;
      RA_DIV:  rd_data[3:0]       = div_q;
      RA_DL:   rd_data            = dl_mode ? dl_q : {DATA_W{1'b0}};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
  parameter int TS_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sw_enable,
  input logic            wr_en,
  input logic [2:0]      wr_addr,
  input logic [TS_W-1:0] wr_data,
  input logic [TS_W-1:0] tsc,
  input logic [1:0]      mode_q,
  input logic            mask_q,
  input logic [7:0]      vec_q,
  input logic [31:0]     init_q,
  input logic [TS_W-1:0] dl_q,
  input logic            cd_run,
  input logic            dl_arm,
  input logic            irq_valid,
  input logic [7:0]      irq_vector
);
  AST_DISABLED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0 && !sw_enable) |=> mask_q); // R2

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |=> !irq_valid); // R3

  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == $past(vec_q))); // R4

  AST_ZERO_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1 && mode_q != 2'b10 && wr_data[31:0] == 32'd0) |=> !cd_run); // R7

  AST_MODE_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0 && wr_data[18:17] != mode_q) |=> (!cd_run && !dl_arm)); // R9

  AST_INIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1 && mode_q == 2'b10) |=> $stable(init_q)); // R10

  AST_DL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd4 && mode_q != 2'b10) |=> $stable(dl_q)); // R11

  AST_DL_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_arm && tsc >= dl_q && !wr_en && !mask_q) |=> irq_valid); // R12
endmodule

bind core_irq_timer tmr_checker #(.TS_W(TS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_enable  (sw_enable),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .tsc        (tsc),
  .mode_q     (mode_q),
  .mask_q     (mask_q),
  .vec_q      (vec_q),
  .init_q     (init_q),
  .dl_q       (dl_q),
  .cd_run     (cd_run),
  .dl_arm     (dl_arm),
  .irq_valid  (irq_valid),
  .irq_vector (irq_vector)
);

// File: tb/sim_core_irq_timer.sv
`timescale 1ns/1ps
module sim_core_irq_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_enable = 1'b1;
  logic [63:0] tsc = 64'd1000;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [63:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd0;
  logic [63:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 0;
  string ph      = "R1";

  always #2.5 clk = ~clk;

  core_irq_timer u0 (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .tsc(tsc),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  initial forever begin
    @(posedge clk); #1; tsc = tsc + 64'd1;
  end

  // behavioural reference model
  logic [1:0]  m_mode;
  logic        m_mask;
  logic [7:0]  m_vec;
  logic [31:0] m_init, m_cur;
  logic [3:0]  m_div;
  logic [63:0] m_dl;
  bit          m_run, m_arm, e_irq;
  logic [7:0]  e_vec;
  int          m_pc;

  always @(posedge clk) begin
    int  f;
    bit  tk, chg, wi, wd, hit, was_run;
    if (!rst_n) begin
      m_mode = 2'b00; m_mask = 1'b1; m_vec = '0; m_init = '0; m_cur = '0;
      m_div = '0; m_dl = '0; m_run = 0; m_arm = 0; m_pc = 0;
      e_irq = 0; e_vec = '0;
    end else begin
      f   = 1 << ((int'({m_div[3], m_div[1:0]}) + 1) % 8);
      tk  = m_run && (m_pc >= f - 1);
      chg = wr_en && wr_addr == 3'd0 && wr_data[18:17] != m_mode;
      wi  = wr_en && wr_addr == 3'd1 && m_mode != 2'b10;
      wd  = wr_en && wr_addr == 3'd4 && m_mode == 2'b10;
      hit = (tk && m_cur == 32'd1 && !chg && !wi) || (m_arm && tsc >= m_dl && !chg && !wd);
      e_irq = hit && !m_mask;
      e_vec = e_irq ? m_vec : 8'd0;
      was_run = m_run;
      if (chg) begin
        m_run = 0; m_cur = '0; m_arm = 0;
      end else if (wi) begin
        m_init = wr_data[31:0]; m_cur = wr_data[31:0]; m_run = (wr_data[31:0] != 0);
      end else if (m_run && tk) begin
        if (m_cur == 32'd1) begin
          if (m_mode == 2'b01) m_cur = m_init;
          else begin m_cur = '0; m_run = 0; end
        end else m_cur = m_cur - 1;
      end
      if (chg || wi || !was_run || tk) m_pc = 0; else m_pc = m_pc + 1;
      if (wd) begin
        m_dl = wr_data; m_arm = (wr_data != 0);
      end else if (!chg && m_arm && tsc >= m_dl) m_arm = 0;
      if (wr_en && wr_addr == 3'd0) begin
        m_mode = wr_data[18:17]; m_mask = wr_data[16] | ~sw_enable; m_vec = wr_data[7:0];
      end
      if (wr_en && wr_addr == 3'd3) m_div = wr_data[3:0] & 4'b1011;
    end
  end

  function automatic logic [63:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {45'd0, m_mode, m_mask, 8'd0, m_vec};
      3'd1: return {32'd0, m_init};
      3'd2: return (m_mode == 2'b10) ? 64'd0 : {32'd0, m_cur};
      3'd3: return {60'd0, m_div};
      3'd4: return (m_mode == 2'b10) ? m_dl : 64'd0;
      default: return 64'd0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (irq_valid !== e_irq || irq_vector !== e_vec || rd_data !== exp_rd(rd_addr)) begin
        errors++;
        $display("FAIL %s cycle compare: irq=%0b vec=%0h rd[%0d]=%0h expected irq=%0b vec=%0h rd=%0h",
                 ph, irq_valid, irq_vector, rd_addr, rd_data, e_irq, e_vec, exp_rd(rd_addr));
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    @(posedge clk); #1;
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  // cycles from write edge to pulse, counted in negedges (N*F+1)
  task automatic wait_irq(input int maxc, output int cyc);
    bit found = 0;
    cyc = 0;
    while (!found && cyc < maxc) begin
      @(negedge clk); cyc++;
      if (irq_valid) found = 1;
    end
    if (!found) cyc = -1;
  endtask

  task automatic count_irq(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_valid) c++;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    ph = "R1";
    rd(3'd0, v); chk("R1 ctrl reset", v, 64'h10000);
    rd(3'd1, v); chk("R1 init reset", v, 64'd0);
    rd(3'd3, v); chk("R1 div reset", v, 64'd0);
    rd(3'd4, v); chk("R1 deadline reset", v, 64'd0);
    chk("R1 no irq", {63'd0, irq_valid}, 64'd0);

    ph = "R2";
    sw_enable = 1'b0;
    wr(3'd0, 64'h41);
    rd(3'd0, v); chk("R2 forced mask", v, 64'h10041);
    sw_enable = 1'b1;
    wr(3'd0, 64'h41);
    rd(3'd0, v); chk("R2 ctrl store", v, 64'h41);

    ph = "R4";
    rd_addr = 3'd2;
    wr(3'd3, 64'h0);
    wr(3'd1, 64'd5);
    wait_irq(100, c); chk("R4 one-shot interval 5x2", c, 11);
    chk("R4 vector", {56'd0, irq_vector}, 64'h41);
    count_irq(30, c); chk("R4 single pulse", c, 0);
    rd(3'd2, v); chk("R4 cur zero after", v, 0);

    ph = "R6";
    wr(3'd3, 64'hB);
    wr(3'd1, 64'd4);
    wait_irq(100, c); chk("R6 factor 1", c, 5);
    wr(3'd3, 64'h3);
    wr(3'd1, 64'd2);
    wait_irq(100, c); chk("R6 factor 16", c, 33);

    ph = "R5";
    wr(3'd3, 64'hB);
    wr(3'd0, 64'h20041);
    wr(3'd1, 64'd3);
    wait_irq(50, c); chk("R5 first period", c, 4);
    wait_irq(50, c); chk("R5 reload period", c, 3);
    wait_irq(50, c); chk("R5 third period", c, 3);

    ph = "R8";
    wr(3'd1, 64'd10);
    repeat (5) @(posedge clk);
    wr(3'd1, 64'd10);
    wait_irq(50, c); chk("R8 restart interval", c, 11);

    ph = "R7";
    wr(3'd1, 64'd0);
    count_irq(40, c); chk("R7 zero no start", c, 0);
    rd(3'd2, v); chk("R7 cur zero", v, 0);

    ph = "R3";
    wr(3'd0, 64'h30041);
    wr(3'd1, 64'd2);
    count_irq(20, c); chk("R3 masked quiet", c, 0);
    wr(3'd0, 64'h20041);
    wait_irq(10, c); chk("R3 unmask resumes", {63'd0, c > 0}, 64'd1);

    ph = "R9";
    wr(3'd0, 64'h41);
    wr(3'd1, 64'd20);
    repeat (5) @(posedge clk);
    wr(3'd0, 64'h20041);
    count_irq(40, c); chk("R9 mode change cancels", c, 0);
    rd(3'd2, v); chk("R9 cur cleared", v, 0);

    ph = "R10";
    wr(3'd0, 64'h40041);
    rd(3'd2, v); chk("R10 cur reads 0", v, 0);
    wr(3'd1, 64'd7);
    rd(3'd1, v); chk("R10 init write ignored", v, 64'd20);
    count_irq(20, c); chk("R10 no count started", c, 0);

    ph = "R12";
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = tsc + 64'd20;
    @(posedge clk); #1; wr_en = 1'b0;
    wait_irq(60, c); chk("R12 future deadline", c, 21);
    wr(3'd4, 64'd5);
    wait_irq(10, c); chk("R12 past deadline at once", c, 2);
    rd(3'd4, v); chk("R12 deadline readback", v, 64'd5);
    wr(3'd4, 64'd0);
    count_irq(20, c); chk("R12 zero disarms", c, 0);

    ph = "R11";
    wr(3'd0, 64'h41);
    rd(3'd4, v); chk("R11 deadline reads 0", v, 0);
    wr(3'd4, 64'd3);
    count_irq(10, c); chk("R11 no deadline fire", c, 0);
    wr(3'd0, 64'h40041);
    rd(3'd4, v); chk("R11 write was ignored", v, 0);

    ph = "R13";
    wr(3'd0, 64'h60041);
    wr(3'd1, 64'd3);
    wait_irq(20, c); chk("R13 spare acts one-shot", c, 4);
    count_irq(20, c); chk("R13 no reload", c, 0);
    rd(3'd2, v); chk("R13 cur zero", v, 0);

    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule